// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Device Identification

This block is the serial test port of a chip. A test controller drives a test clock, a mode-select line and a serial data input. A sixteen-state controller walks through capture, shift and update phases for two paths: the instruction path and the data path. The current instruction decides which data register sits between the serial input and the serial output. The available registers are a one-bit pass-through register, a 32-bit device identification word, a small boundary register stub and a one-bit configuration status register.

The identification word is built from four parameters: die version, family, array dimension and manufacturer code. Bit 0 of the word is always 1. A data register is clocked only while an instruction that selects it is active. The configuration instruction produces a strobe that lasts one test-clock cycle. That instruction can be loaded again to retry after an attempt that did not finish. A disable input suppresses the strobe.

Top module: `jtag_tap_id`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the controller goes to Test-Logic-Reset. After that edge `tdo_oe`, `cfg_strobe`, `extest_en` and `io_out` are all 0. Whenever the controller is in Test-Logic-Reset, the identification instruction becomes the current instruction.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, whatever `tdi` does. The controller stays there while `tms` remains high.
- R3: The identification word is {version[3:0], family[6:0], array[8:0], manufacturer[10:0], 1'b1}, with the version in bits 31:28 and bit 0 fixed at 1. With the defaults (version 0, family 0x02, array 0x1C, manufacturer 0x49) it reads 0x0041C093. Under the identification instruction it is loaded at Capture-DR and shifted out least significant bit first.
- R4: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, so the low two bits read 01. The instruction codes are: 0000 drive-from-boundary, 0001 sample/preload, 0010 identification, 0101 configure, 0111 configuration status, 1111 bypass.
- R5: The bypass code and every code not listed in R4 select the one-bit bypass register. That register captures 0 and delays the serial data by one `tck`. It is clocked only while it is selected.
- R6: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only in Shift-DR and Shift-IR.
- R7: Under sample/preload and under drive-from-boundary, the boundary stub captures `io_in` at Capture-DR and shifts `tdi` in. At Update-DR it copies its contents to `io_out`. `extest_en` is 1 exactly while drive-from-boundary is the current instruction.
- R8: Under any other instruction, the boundary stub is not clocked and `io_out` keeps its value through scans and updates.
- R9: Each Update-IR that loads the configure code raises `cfg_strobe` for exactly one `tck` cycle, starting at the edge that leaves Update-IR. Loading the code again produces another pulse.
- R10: If `cfg_disable` is high at the edge that leaves Update-IR, no strobe is produced.
- R11: Under the configuration status instruction, a one-bit register captures `cfg_done` at Capture-DR and shifts it out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on the rising `tck` edge |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| cfg_disable | input | 1 | Blocks the configure strobe when high |
| cfg_done | input | 1 | Configuration state, read through the status register |
| io_in | input | BS_LEN | Pin values captured by the boundary stub |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| io_out | output | BS_LEN | Boundary update latch contents |
| extest_en | output | 1 | High while drive-from-boundary is the current instruction |
| cfg_strobe | output | 1 | One-cycle configure pulse |

## Verification
The controller state changes on every rising edge. Each serial bit reaches `tdo` half a cycle later, at the next falling edge. The bench therefore reads `tdo` 1.5 ns after a falling edge, so the first bit of a scan is the captured least significant bit, and it reads it before driving the next rising edge. `io_out` and `cfg_strobe` are registered at the rising edge that leaves Update-DR or Update-IR. The bench samples them right after that edge's cycle ends, and it samples the strobe again one cycle later to confirm the pulse lasts exactly one cycle. One directed case reads `tdo` between a rising edge and the following falling edge, to prove that no change happens on the rising edge.

// File: rtl/jtag_tap_pkg.sv
// Package: shared state encoding, instruction codes and data-register
// selector for the test access port. Assumes a 4-bit instruction register.
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_CONFIG  = 4'b0101;
    localparam logic [IR_W-1:0] OP_CFGSTAT = 4'b0111;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_ID, DR_BOUND, DR_STAT
    } dr_sel_t;

endpackage

// File: rtl/tap_fsm.sv
// Module: sixteen-state test controller, advanced on each rising tck edge.
// Assumes trst_n is sampled synchronously to tck.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and tms
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // Checker counter: consecutive tms-high edges, saturating at five
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (!trst_n)         ones_q <= 3'd5;
        else if (!tms)       ones_q <= 3'd0;
        else if (ones_q < 5) ones_q <= ones_q + 3'd1;
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state == ST_RESET));

    // R2
    hold_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Module: instruction shift/update register, instruction decode and the
// configure strobe. Assumes the controller state comes from tap_fsm.
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  logic       cfg_disable,
    output logic       ir_so,
    output dr_sel_t    dr_sel,
    output logic       extest_en,
    output logic       cfg_strobe
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    // Instruction shift register: capture fixed pattern, shift LSB first
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction: identification on reset, new code on update
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)      ir_q <= ir_sr;
    end

    // One-cycle configure pulse on each update of the configure code
    always_ff @(posedge tck) begin
        if (!trst_n) cfg_strobe <= 1'b0;
        else         cfg_strobe <= (state == ST_UPD_IR) && (ir_sr == OP_CONFIG) && !cfg_disable;
    end

    // Decode the current instruction to a data-register selection
    always_comb begin
        case (ir_q)
            OP_IDCODE:             dr_sel = DR_ID;
            OP_SAMPLE, OP_EXTEST:  dr_sel = DR_BOUND;
            OP_CFGSTAT:            dr_sel = DR_STAT;
            default:               dr_sel = DR_BYPASS;
        endcase
    end

    assign extest_en = (ir_q == OP_EXTEST);
    assign ir_so     = ir_sr[0];

    // R1
    reset_loads_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_q == OP_IDCODE));

    // R9
    strobe_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
        cfg_strobe |=> !cfg_strobe);

    // R10
    strobe_blocked_chk: assert property (@(posedge tck) disable iff (!trst_n)
        cfg_strobe |-> !$past(cfg_disable));

endmodule

// File: rtl/tap_dr.sv
// Module: data registers (bypass, identification, boundary stub, status)
// with per-instruction clock enables. Assumes dr_sel is stable during a scan.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0]  DIE_VERSION = 4'h0,
    parameter logic [6:0]  FAMILY_CODE = 7'h02,
    parameter logic [8:0]  ARRAY_DIM   = 9'h01C,
    parameter logic [10:0] MFR_CODE    = 11'h049,
    parameter int          BS_LEN      = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_t        state,
    input  dr_sel_t           dr_sel,
    input  logic              cfg_done,
    input  logic [BS_LEN-1:0] io_in,
    output logic              dr_so,
    output logic [BS_LEN-1:0] io_out
);

    localparam logic [31:0] ID_WORD = {DIE_VERSION, FAMILY_CODE, ARRAY_DIM, MFR_CODE, 1'b1};

    logic              cap, sh, upd;
    logic              en_byp, en_id, en_bs, en_st;
    logic              byp_q, stat_q;
    logic [31:0]       id_sr;
    logic [BS_LEN-1:0] bs_sr, bs_next;

    assign cap = (state == ST_CAP_DR);
    assign sh  = (state == ST_SH_DR);
    assign upd = (state == ST_UPD_DR);

    // Per-register clock enables derived from the selection
    assign en_byp = (dr_sel == DR_BYPASS);
    assign en_id  = (dr_sel == DR_ID);
    assign en_bs  = (dr_sel == DR_BOUND);
    assign en_st  = (dr_sel == DR_STAT);

    // Boundary shift path; a one-cell stub takes tdi directly
    if (BS_LEN > 1) begin : g_bs_wide
        assign bs_next = {tdi, bs_sr[BS_LEN-1:1]};
    end else begin : g_bs_one
        assign bs_next = tdi;
    end

    // Bypass flop, clocked only under bypass selection
    always_ff @(posedge tck) begin
        if (!trst_n)           byp_q <= 1'b0;
        else if (en_byp && cap) byp_q <= 1'b0;
        else if (en_byp && sh)  byp_q <= tdi;
    end

    // Identification register: load word, shift LSB first
    always_ff @(posedge tck) begin
        if (!trst_n)          id_sr <= '0;
        else if (en_id && cap) id_sr <= ID_WORD;
        else if (en_id && sh)  id_sr <= {tdi, id_sr[31:1]};
    end

    // Boundary stub shift stage
    always_ff @(posedge tck) begin
        if (!trst_n)          bs_sr <= '0;
        else if (en_bs && cap) bs_sr <= io_in;
        else if (en_bs && sh)  bs_sr <= bs_next;
    end

    // Boundary stub update latch
    always_ff @(posedge tck) begin
        if (!trst_n)          io_out <= '0;
        else if (en_bs && upd) io_out <= bs_sr;
    end

    // Configuration status bit
    always_ff @(posedge tck) begin
        if (!trst_n)          stat_q <= 1'b0;
        else if (en_st && cap) stat_q <= cfg_done;
        else if (en_st && sh)  stat_q <= tdi;
    end

    // Serial output of the selected register
    always_comb begin
        unique case (dr_sel)
            DR_ID:    dr_so = id_sr[0];
            DR_BOUND: dr_so = bs_sr[0];
            DR_STAT:  dr_so = stat_q;
            default:  dr_so = byp_q;
        endcase
    end

    // R5
    bypass_gated_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !en_byp |=> $stable(byp_q));

    // R8
    boundary_gated_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !en_bs |=> $stable(io_out));

endmodule

// File: rtl/jtag_tap_id.sv
// Module: top of the test access port. Joins controller, instruction and
// data paths; drives tdo and its enable from a falling-edge register.
module jtag_tap_id
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0]  DIE_VERSION = 4'h0,
    parameter logic [6:0]  FAMILY_CODE = 7'h02,
    parameter logic [8:0]  ARRAY_DIM   = 9'h01C,
    parameter logic [10:0] MFR_CODE    = 11'h049,
    parameter int          BS_LEN      = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic              cfg_disable,
    input  logic              cfg_done,
    input  logic [BS_LEN-1:0] io_in,
    output logic              tdo,
    output logic              tdo_oe,
    output logic [BS_LEN-1:0] io_out,
    output logic              extest_en,
    output logic              cfg_strobe
);

    tap_state_t state;
    dr_sel_t    dr_sel;
    logic       ir_so, dr_so;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .cfg_disable(cfg_disable), .ir_so(ir_so), .dr_sel(dr_sel),
        .extest_en(extest_en), .cfg_strobe(cfg_strobe)
    );

    tap_dr #(
        .DIE_VERSION(DIE_VERSION), .FAMILY_CODE(FAMILY_CODE),
        .ARRAY_DIM(ARRAY_DIM), .MFR_CODE(MFR_CODE), .BS_LEN(BS_LEN)
    ) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .dr_sel(dr_sel),
        .cfg_done(cfg_done), .io_in(io_in), .dr_so(dr_so), .io_out(io_out)
    );

    // Falling-edge output stage for serial data and its enable
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
            tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
        end
    end

    // R6
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

// File: tb/jtag_tap_id_tb.sv
module jtag_tap_id_tb;

    localparam int BS = 4;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic cfg_disable = 1'b0, cfg_done = 1'b0;
    logic [BS-1:0] io_in = '0;
    logic tdo, tdo_oe, extest_en, cfg_strobe;
    logic [BS-1:0] io_out;
    logic tdo2, tdo_oe2, extest_en2, cfg_strobe2;
    logic [BS-1:0] io_out2;

    int checks = 0, failures = 0;
    bit done = 0;

    jtag_tap_id #(.BS_LEN(BS)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .cfg_disable(cfg_disable), .cfg_done(cfg_done), .io_in(io_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .io_out(io_out),
        .extest_en(extest_en), .cfg_strobe(cfg_strobe)
    );

    // second instance with other identification fields (R3)
    jtag_tap_id #(.DIE_VERSION(4'h3), .ARRAY_DIM(9'h00A), .BS_LEN(BS)) u_dut2 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .cfg_disable(cfg_disable), .cfg_done(cfg_done), .io_in(io_in),
        .tdo(tdo2), .tdo_oe(tdo_oe2), .io_out(io_out2),
        .extest_en(extest_en2), .cfg_strobe(cfg_strobe2)
    );

    function automatic logic [31:0] id_word(logic [3:0] v, logic [6:0] f,
                                            logic [8:0] a, logic [10:0] m);
        return {v, f, a, m, 1'b1};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one 5 ns tck cycle; outputs sampled 1.5 ns after the falling edge
    task automatic tick(logic m, logic d);
        tms = m; tdi = d;
        #1 tck = 1'b1;
        #2.5 tck = 1'b0;
        #1.5;
    endtask

    task automatic load_ir(logic [3:0] code, output logic [3:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            tick(i == 3, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(int n, logic [63:0] din,
                           output logic [63:0] dout, output logic [63:0] dout2);
        dout = '0; dout2 = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R6 oe in shift", tdo_oe, 1);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo; dout2[i] = tdo2;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
        chk("R6 oe idle", tdo_oe, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] cap;
        logic [63:0] o, o2, din;
        logic [BS-1:0] pat;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) tick($urandom % 2, $urandom % 2);
        chk("R1 oe", tdo_oe, 0);
        chk("R1 strobe", cfg_strobe, 0);
        chk("R1 extest", extest_en, 0);
        chk("R1 io_out", io_out, 0);
        trst_n = 1'b1;
        tick(0, 0);
        // R1/R3: identification is the instruction after reset
        scan_dr(32, 64'h0, o, o2);
        chk("R3 default id", o, 64'h0041C093);
        chk("R3 id word", o, id_word(4'h0, 7'h02, 9'h01C, 11'h049));
        chk("R3 alt id", o2, id_word(4'h3, 7'h02, 9'h00A, 11'h049));

        // R4: capture pattern
        load_ir(4'b1111, cap);
        chk("R4 ir capture", cap, 4'b0001);

        // R5: bypass delays by one, captures 0 (bypass and unknown codes)
        for (int k = 0; k < 6; k++) begin
            load_ir(k < 3 ? 4'b1111 : 4'b1010, cap);
            din = {$urandom, $urandom};
            scan_dr(16, din, o, o2);
            chk("R5 bypass", o[15:0], {din[14:0], 1'b0});
        end

        // R6: tdo does not move on the rising edge
        load_ir(4'b1111, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R6 first bit", tdo, 0);
        tms = 0; tdi = 1;
        #1 tck = 1'b1;
        #1 chk("R6 rising edge", tdo, 0);
        #1.5 tck = 1'b0;
        #1.5 chk("R6 falling edge", tdo, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R2: random walks followed by five tms-high edges
        for (int k = 0; k < 20; k++) begin
            load_ir(4'b1111, cap);
            for (int j = 0; j < 1 + ($urandom % 12); j++) tick($urandom % 2, $urandom % 2);
            for (int j = 0; j < 5 + ($urandom % 4); j++) tick(1, $urandom % 2);
            chk("R2 oe in reset", tdo_oe, 0);
            tick(0, 0);
            scan_dr(32, 64'h0, o, o2);
            chk("R2 reset gives id", o, 64'h0041C093);
        end

        // R7: sample/preload captures io_in and updates io_out
        for (int k = 0; k < 4; k++) begin
            io_in = BS'($urandom);
            pat = BS'($urandom);
            load_ir(4'b0001, cap);
            chk("R7 extest off", extest_en, 0);
            scan_dr(BS, 64'(pat), o, o2);
            chk("R7 capture", o[BS-1:0], io_in);
            chk("R7 update", io_out, pat);
        end
        load_ir(4'b0000, cap);
        chk("R7 extest on", extest_en, 1);
        pat = 4'b1010;
        scan_dr(BS, 64'(pat), o, o2);
        chk("R7 extest update", io_out, pat);

        // R8: other instructions leave io_out untouched
        load_ir(4'b0010, cap);
        chk("R7 extest cleared", extest_en, 0);
        scan_dr(32, {$urandom, $urandom}, o, o2);
        chk("R8 id scan", io_out, pat);
        load_ir(4'b1111, cap);
        scan_dr(8, 64'hFF, o, o2);
        chk("R8 bypass scan", io_out, pat);

        // R9: configure strobe pulses and can be reissued
        load_ir(4'b0101, cap);
        chk("R9 strobe", cfg_strobe, 1);
        tick(0, 0);
        chk("R9 strobe one cycle", cfg_strobe, 0);
        load_ir(4'b0101, cap);
        chk("R9 reissue", cfg_strobe, 1);
        tick(0, 0);

        // R10: disable suppresses strobe
        cfg_disable = 1'b1;
        load_ir(4'b0101, cap);
        chk("R10 blocked", cfg_strobe, 0);
        cfg_disable = 1'b0;

        // R11: status register reports cfg_done
        load_ir(4'b0111, cap);
        cfg_done = 1'b1;
        scan_dr(1, 64'h0, o, o2);
        chk("R11 done high", o[0], 1);
        cfg_done = 1'b0;
        scan_dr(1, 64'h1, o, o2);
        chk("R11 done low", o[0], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule